// File: doc/BRIEF.md
# Rotating-Key Stream Cipher Receiver

This block turns a serial cipher bitstream back into bytes. Once an external authorisation strobe arrives, an 8-bit key pattern is captured into a circular key register. Each accepted cipher bit is XORed with the key register's least significant bit. The key register then rotates right by one place, so the same 8-bit keystream repeats for every word. The plain bits enter a serial-in parallel-out register from the most significant end.

After the eighth accepted bit, the recovered byte is flagged with a single-cycle valid pulse. In that same cycle an optional 256-line one-hot decode of the byte is driven. Before authorisation the block discards all cipher bits. Cipher bits may arrive with idle cycles between them, and only cycles with the bit strobe high advance the word.

Top module: `keyrx_top`

## Requirements
- R1: After synchronous active-low reset, `key_armed`, `byte_valid`, `byte_out` and `byte_onehot` are all zero.
- R2: A cycle with `auth_grant` high captures `key_pattern`, sets `key_armed`, restarts the word at bit 0 and clears `byte_out`, even when a word was partly received.
- R3: The key bit applied to the k-th accepted bit of a word (k = 0..7) is bit k of the captured pattern. The register rotates right and its bit 0 is used, so every word reuses the same keystream.
- R4: Each plain bit is the cipher bit XOR the key bit. It enters `byte_out[7]` while the register shifts right, so the first bit of a word ends in `byte_out[0]`.
- R5: With pattern 8'hE8 and cipher bits 0,1,0,1,0,0,0,1 in arrival order, the recovered byte is 8'h62 (decimal 98).
- R6: `byte_valid` is high for exactly one cycle. That cycle follows the clock edge that accepted the eighth bit of a word, and `byte_out` holds the completed byte in it.
- R7: `byte_onehot[n]` is 1 only when `byte_valid` is high and `byte_out` equals n. At all other times every line of `byte_onehot` is 0.
- R8: While `key_armed` is low, cipher bits are ignored: `byte_out` does not change and no `byte_valid` pulse occurs.
- R9: Cycles with `bit_valid` low neither shift the registers nor advance the word, so gaps between bits do not change the recovered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auth_grant | input | 1 | Authorisation strobe; captures the key and arms the receiver |
| key_pattern | input | 8 | Key pattern captured on `auth_grant` |
| bit_valid | input | 1 | Marks `cipher_bit` as a new bit this cycle |
| cipher_bit | input | 1 | Serial cipher input |
| key_armed | output | 1 | A key has been captured since reset |
| byte_out | output | 8 | Recovered byte, first bit in bit 0 |
| byte_valid | output | 1 | One-cycle pulse marking a completed byte |
| byte_onehot | output | 256 | One-hot decode of `byte_out`, gated by `byte_valid` |

## Verification
The assertions assume that `auth_grant` and `bit_valid` are sampled as plain synchronous levels. They also assume that a bit accepted in the same cycle as `auth_grant` is dropped on purpose. The bench therefore never raises the two strobes together, except in the mid-word reload case, where the assertions do not depend on that bit. The bench drives all inputs at the falling edge, so every strobe is a full-cycle level. It sweeps all 256 bytes under several keys, both with and without idle gaps, so the single-cycle valid pulse and the one-hot gate are exercised at every code.

// File: rtl/keyrx_pkg.sv
// Shared sizing for the cipher receiver.
// Assumes: one word equals one byte of recovered data.
package keyrx_pkg;
    parameter int unsigned KRX_WORD_W = 8;
    parameter logic [7:0]  KRX_RESET_KEY = 8'h00;
endpackage

// File: rtl/keyrx_key_rotator.sv
// Circular key register: captures a pattern on load and rotates right by
// one place on each step, exposing bit 0 as the current key bit.
// Assumes: load and step are never high together (load wins).
module keyrx_key_rotator #(
    parameter int unsigned WIDTH = keyrx_pkg::KRX_WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] pattern,
    input  logic             step,
    output logic             key_bit
);
    logic [WIDTH-1:0] key_q;

    // Purpose: hold the key, capture on load, rotate right on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= WIDTH'(keyrx_pkg::KRX_RESET_KEY);
        end else if (load) begin
            key_q <= pattern;
        end else if (step) begin
            key_q <= {key_q[0], key_q[WIDTH-1:1]};
        end
    end

    assign key_bit = key_q[0];

    // A rotation neither creates nor loses key bits (R3).
    p_rotate_keeps_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ($countones(key_q) == $countones($past(key_q))));
endmodule

// File: rtl/keyrx_sipo.sv
// Serial-in parallel-out capture: new bit enters the top, register shifts right.
// Assumes: clear has priority over shift.
module keyrx_sipo #(
    parameter int unsigned WIDTH = keyrx_pkg::KRX_WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    logic [WIDTH-1:0] word_q;

    // Purpose: collect plain bits, first bit drifting down to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_q <= '0;
        end else if (shift) begin
            word_q <= {din, word_q[WIDTH-1:1]};
        end
    end

    assign word = word_q;

    // The newest bit lands in the top position (R4).
    p_msb_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clear) |=> (word_q[WIDTH-1] == $past(din)));
    // Idle cycles leave the capture untouched (R9).
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clear) |=> $stable(word_q));
endmodule

// File: rtl/keyrx_onehot.sv
// Gated one-hot decoder of a WIDTH-bit value into 2**WIDTH lines.
// Assumes: ENABLE selects whether the decode exists at all.
module keyrx_onehot #(
    parameter int unsigned WIDTH  = keyrx_pkg::KRX_WORD_W,
    parameter bit          ENABLE = 1'b1,
    localparam int unsigned LINES = 1 << WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] value,
    output logic [LINES-1:0] lines
);
    generate
        if (ENABLE) begin : g_decode
            for (genvar i = 0; i < LINES; i++) begin : g_line
                // Purpose: raise line i when enabled and the value matches.
                assign lines[i] = en && (value == WIDTH'(i));
            end
            // Exactly one line when enabled (R7).
            p_one_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
                en |-> ($countones(lines) == 1));
        end else begin : g_none
            assign lines = '0;
        end
    endgenerate

    // No line while disabled (R7).
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (lines == '0));
endmodule

// File: rtl/keyrx_top.sv
// Cipher receiver top: gates bits on authorisation, XORs each with the
// rotating key bit, assembles words and flags each completed one.
// Assumes: auth_grant and bit_valid are synchronous levels; a bit offered
// in the same cycle as auth_grant is dropped.
module keyrx_top #(
    parameter int unsigned WORD_W    = keyrx_pkg::KRX_WORD_W,
    parameter bit          DECODE_EN = 1'b1,
    localparam int unsigned CNT_W    = $clog2(WORD_W),
    localparam int unsigned LINES    = 1 << WORD_W,
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auth_grant,
    input  logic [WORD_W-1:0] key_pattern,
    input  logic              bit_valid,
    input  logic              cipher_bit,
    output logic              key_armed,
    output logic [WORD_W-1:0] byte_out,
    output logic              byte_valid,
    output logic [LINES-1:0]  byte_onehot
);
    logic             armed_q;
    logic [CNT_W-1:0] idx_q;
    logic             valid_q;
    logic             key_bit;
    logic             accept;
    logic             last_bit;

    assign accept   = bit_valid && armed_q && !auth_grant;
    assign last_bit = accept && (idx_q == LAST_IDX);

    // Purpose: track authorisation, bit position in word and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= last_bit;
            if (auth_grant) begin
                armed_q <= 1'b1;
                idx_q   <= '0;
            end else if (accept) begin
                idx_q <= last_bit ? '0 : idx_q + 1'b1;
            end
        end
    end

    keyrx_key_rotator #(.WIDTH(WORD_W)) i_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (auth_grant),
        .pattern (key_pattern),
        .step    (accept),
        .key_bit (key_bit)
    );

    keyrx_sipo #(.WIDTH(WORD_W)) i_sipo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (auth_grant),
        .shift (accept),
        .din   (cipher_bit ^ key_bit),
        .word  (byte_out)
    );

    keyrx_onehot #(.WIDTH(WORD_W), .ENABLE(DECODE_EN)) i_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (valid_q),
        .value (byte_out),
        .lines (byte_onehot)
    );

    assign key_armed  = armed_q;
    assign byte_valid = valid_q;

    // Completion flag never lasts two cycles (R6).
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    // Unarmed receiver is inert (R8).
    p_unarmed_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_armed && !auth_grant) |=> ($stable(byte_out) && !byte_valid));
    // Authorisation always arms and clears the capture (R2).
    p_auth_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        auth_grant |=> (key_armed && byte_out == '0 && !byte_valid));
endmodule

// File: tb/test_keyrx_top.sv
`timescale 1ns/1ps
module test_keyrx_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         auth_grant;
    logic [7:0]   key_pattern;
    logic         bit_valid;
    logic         cipher_bit;
    logic         key_armed;
    logic [7:0]   byte_out;
    logic         byte_valid;
    logic [255:0] byte_onehot;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    keyrx_top i_keyrx_top (
        .clk(clk), .rst_n(rst_n), .auth_grant(auth_grant),
        .key_pattern(key_pattern), .bit_valid(bit_valid),
        .cipher_bit(cipher_bit), .key_armed(key_armed),
        .byte_out(byte_out), .byte_valid(byte_valid),
        .byte_onehot(byte_onehot)
    );

    task automatic check(input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic authorise(input logic [7:0] k);
        @(negedge clk);
        auth_grant  = 1'b1;
        key_pattern = k;
        bit_valid   = 1'b0;
        @(negedge clk);
        auth_grant = 1'b0;
    endtask

    // Drive one bit for a single cycle, optionally followed by idle cycles.
    task automatic drive_bit(input logic b, input int gap);
        @(negedge clk);
        bit_valid  = 1'b1;
        cipher_bit = b;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_valid  = 1'b0;
            cipher_bit = ~b;
        end
    endtask

    // Encrypt p with key k, send it, check byte, valid pulse and decode.
    task automatic send_byte(input logic [7:0] p, input logic [7:0] k,
                             input bit gaps);
        for (int i = 0; i < 8; i++) begin
            drive_bit(p[i] ^ k[i], (gaps && i == 3) ? 2 : 0);
        end
        @(negedge clk);
        bit_valid = 1'b0;
        check(gaps ? "R9 byte with gaps" : "R3 R4 recovered byte", byte_out, p);
        check("R6 valid pulse high", byte_valid, 1'b1);
        check("R7 one-hot line", byte_onehot, 256'(1) << p);
        @(negedge clk);
        check("R6 valid pulse single", byte_valid, 1'b0);
        check("R7 one-hot quiet", byte_onehot, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        wrap_up();
    end

    initial begin
        logic [7:0] ex_bits;
        rst_n = 1'b0; auth_grant = 1'b0; key_pattern = '0;
        bit_valid = 1'b0; cipher_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 armed", key_armed, 1'b0);
        check("R1 byte", byte_out, 8'h00);
        check("R1 valid", byte_valid, 1'b0);
        check("R1 one-hot", byte_onehot, '0);

        // R8 bits before authorisation are ignored
        for (int i = 0; i < 10; i++) begin
            drive_bit(1'b1, 0);
            @(negedge clk);
            bit_valid = 1'b0;
            check("R8 byte unchanged", byte_out, 8'h00);
            check("R8 no valid", byte_valid, 1'b0);
        end

        // R2 authorisation arms
        authorise(8'hE8);
        check("R2 armed", key_armed, 1'b1);
        check("R2 byte cleared", byte_out, 8'h00);

        // R5 worked example: cipher 0,1,0,1,0,0,0,1 in arrival order
        ex_bits = 8'b1000_1010;
        for (int i = 0; i < 8; i++) drive_bit(ex_bits[i], 0);
        @(negedge clk);
        bit_valid = 1'b0;
        check("R5 example byte", byte_out, 8'h62);
        check("R5 example valid", byte_valid, 1'b1);
        check("R7 example line 98", byte_onehot[98], 1'b1);
        @(negedge clk);

        // R2 reload in mid-word restarts the word
        for (int i = 0; i < 3; i++) drive_bit(1'b1, 0);
        @(negedge clk);
        bit_valid = 1'b0;
        authorise(8'h3C);
        check("R2 mid-word clear", byte_out, 8'h00);
        send_byte(8'hA7, 8'h3C, 1'b0);

        // R3 R4 R9 sweeps over all bytes, several keys, plain and gapped
        for (int kk = 0; kk < 3; kk++) begin
            logic [7:0] k;
            k = (kk == 0) ? 8'hE8 : (kk == 1) ? 8'h00 : 8'hA5;
            authorise(k);
            for (int p = 0; p < 256; p++) begin
                send_byte(8'(p), k, (kk == 2) && p[0]);
            end
        end

        // R1 reset drops authorisation again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 armed after reset", key_armed, 1'b0);
        check("R1 byte after reset", byte_out, 8'h00);
        wrap_up();
    end
endmodule